// File: doc/BRIEF.md
# Free Buffer Pointer Pool Allocator

This block gives out free buffer pointers from a circular table of entries held in local storage. Each entry carries a 32-bit pointer, a valid flag and a wrap flag. A consumer asks for a buffer through a valid/ready handshake. The block reads the entry at its fetch index. If the flag is set, the block returns the pointer, clears the flag and moves the index on. An entry whose wrap flag is set sends the index back to the programmed base, so the ring length comes from the table contents and not from counters.

Software puts buffers back by writing whole entries through a host port with the valid flag set. The block itself only ever clears valid flags. A fetch that finds a cleared flag means the pool is empty. The request fails without moving the index. A sticky busy event is raised, and a record carrying the pool's channel code is pushed into a small interrupt queue. When that queue is full, the record is dropped and an overflow flag is set instead.

Top module: `fbp_alloc`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid`, `busy_evt`, `irq_valid` and `irq_ovf` are 0, `fetch_idx` is 0 and every entry has its valid flag cleared.
- R2: A request accepted on a clock edge gets exactly one response in the following cycle, during which `req_ready` is 0. When the entry at `fetch_idx` has its valid flag set, that response has `rsp_ok`=1 and `rsp_ptr` equal to the entry's pointer.
- R3: A successful fetch clears the valid flag of the entry it used, so a later fetch of that entry fails unless the host rewrites it.
- R4: After a successful fetch of an entry whose wrap flag is 0, `fetch_idx` becomes the old index plus one, modulo 2^IDX_W.
- R5: After a successful fetch of an entry whose wrap flag is 1, `fetch_idx` becomes the programmed base index.
- R6: A fetch of an entry whose valid flag is 0 responds with `rsp_ok`=0 and leaves `fetch_idx` unchanged. It also sets `busy_evt`, which stays at 1 until it is cleared.
- R7: A one-cycle pulse on `host_busy_clr` clears `busy_evt`. If a failed fetch sets the event in the same cycle, the event stays at 1.
- R8: Each failed fetch pushes one record onto the interrupt queue. The record's `irq_chan` equals the channel code programmed at that time. Records leave in order, one per cycle in which `irq_valid` and `irq_ready` are both 1.
- R9: A failed fetch that finds the queue holding QDEPTH records drops its record and sets `irq_ovf`. `irq_ovf` stays at 1 until `host_ovf_clr` is pulsed. The records already in the queue are not changed.
- R10: When a host entry write and the block's clear of a valid flag hit the same entry in the same cycle, the host write wins and the entry keeps the host's pointer and flags.
- R11: A pulse on `cfg_we` loads the base index and the channel code and moves `fetch_idx` to the new base. `fetch_idx` always shows the index of the next entry to be fetched.
- R12: The block never sets a valid flag. A flag goes from 0 to 1 only through a host write to that entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Consumer asks for a buffer |
| req_ready | output | 1 | Block can accept a request |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_ok | output | 1 | 1 = pointer handed out, 0 = pool empty |
| rsp_ptr | output | 32 | Pointer handed out (0 when the fetch fails) |
| host_we | input | 1 | Host writes one table entry |
| host_idx | input | IDX_W | Entry index for the host write |
| host_ptr | input | 32 | Pointer to store |
| host_v | input | 1 | Valid flag to store |
| host_w | input | 1 | Wrap flag to store |
| cfg_we | input | 1 | Load base and channel code, and move the fetch index to the base |
| cfg_base | input | IDX_W | New base index |
| cfg_chan | input | CHAN_W | New channel code |
| fetch_idx | output | IDX_W | Index of the next entry to fetch |
| busy_evt | output | 1 | Sticky pool-empty event |
| host_busy_clr | input | 1 | Write-one-to-clear for busy_evt |
| irq_valid | output | 1 | Interrupt record available |
| irq_ready | input | 1 | Consumer takes the head record |
| irq_chan | output | CHAN_W | Channel code of the head record |
| irq_ovf | output | 1 | Sticky: a record was dropped |
| host_ovf_clr | input | 1 | Clears irq_ovf |

## Verification
The hardest case to reach from the ports is the host writing the very entry that the block is clearing in the same cycle. The bench reaches it by starting a fetch, waiting until the response cycle while `fetch_idx` still names the entry being consumed, and then driving a host write to that index on that cycle. It then reprograms the base onto that entry and fetches again to see which value survived. The bench also sweeps every base index against every ring length that fits in the table, checking each pointer, each index step and the empty fetch that ends each lap. Overflow of the interrupt queue is reached by running failed fetches while the queue is never drained.

// File: rtl/fbp_pkg.sv
package fbp_pkg;
    localparam int PTR_W = 32;

    typedef struct packed {
        logic             v;
        logic             w;
        logic [PTR_W-1:0] ptr;
    } fbp_ent_t;

    typedef enum logic {ST_IDLE = 1'b0, ST_CHK = 1'b1} fetch_st_e;

    function automatic logic [PTR_W-1:0] ptr_or_zero(input fbp_ent_t e);
        return e.v ? e.ptr : '0;
    endfunction
endpackage

// File: rtl/fbp_table.sv
module fbp_table
    import fbp_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             host_we,
    input  logic [IDX_W-1:0] host_idx,
    input  fbp_ent_t         host_ent,
    input  logic             blk_clr,
    input  logic [IDX_W-1:0] blk_idx,
    input  logic [IDX_W-1:0] rd_idx,
    output fbp_ent_t         rd_ent
);
    localparam int NENT = 1 << IDX_W;

    fbp_ent_t ent_q [NENT];

    for (genvar i = 0; i < NENT; i++) begin : g_ent
        logic hit_host, hit_blk;
        assign hit_host = host_we && (host_idx == IDX_W'(i));
        assign hit_blk  = blk_clr && (blk_idx == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q[i] <= '0;
            end else if (hit_host) begin
                ent_q[i] <= host_ent;
            end else if (hit_blk) begin
                ent_q[i].v <= 1'b0;
            end
        end

        // R12
        never_self_set_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(ent_q[i].v) |-> $past(host_we && host_idx == IDX_W'(i)));

        // R10
        host_wins_chk: assert property (@(posedge clk) disable iff (rst)
            (hit_host && hit_blk) |=> (ent_q[i] == $past(host_ent)));
    end

    assign rd_ent = ent_q[rd_idx];
endmodule

// File: rtl/fbp_fetch.sv
module fbp_fetch
    import fbp_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  fbp_ent_t         rd_ent,
    output logic             blk_clr,
    output logic             rsp_valid,
    output logic             rsp_ok,
    output logic [PTR_W-1:0] rsp_ptr,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_base,
    output logic [IDX_W-1:0] idx,
    output logic             fail
);
    fetch_st_e        st_q;
    logic [IDX_W-1:0] idx_q, base_q;

    assign req_ready = (st_q == ST_IDLE);
    assign rsp_valid = (st_q == ST_CHK);
    assign rsp_ok    = rsp_valid && rd_ent.v;
    assign rsp_ptr   = rsp_valid ? ptr_or_zero(rd_ent) : '0;
    assign blk_clr   = rsp_ok;
    assign fail      = rsp_valid && !rd_ent.v;
    assign idx       = idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            idx_q  <= '0;
            base_q <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: if (req_valid) st_q <= ST_CHK;
                ST_CHK:  st_q <= ST_IDLE;
            endcase
            if (cfg_we) begin
                base_q <= cfg_base;
                idx_q  <= cfg_base;
            end else if (rsp_ok) begin
                idx_q <= rd_ent.w ? base_q : idx_q + 1'b1;
            end
        end
    end

    // R2
    one_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    // R2
    rsp_after_req_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> rsp_valid);

    // R6
    fail_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (fail && !cfg_we) |=> $stable(idx_q));

    // R4
    step_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_ok && !rd_ent.w && !cfg_we) |=> (idx_q == $past(idx_q) + 1'b1));

    // R5
    wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_ok && rd_ent.w && !cfg_we) |=> (idx_q == $past(base_q)));
endmodule

// File: rtl/fbp_irq_fifo.sv
module fbp_irq_fifo #(
    parameter int CHAN_W = 8,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [CHAN_W-1:0] push_chan,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [CHAN_W-1:0] out_chan,
    output logic              ovf,
    input  logic              ovf_clr
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [CHAN_W-1:0] mem_q [DEPTH];
    logic [AW-1:0]     wp_q, rp_q;
    logic [CW-1:0]     cnt_q;
    logic              full, do_push, do_pop;

    assign full      = (cnt_q == CW'(DEPTH));
    assign out_valid = (cnt_q != '0);
    assign out_chan  = mem_q[rp_q];
    assign do_pop    = out_valid && out_ready;
    assign do_push   = push && !full;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
            ovf   <= 1'b0;
        end else begin
            if (do_push) begin
                mem_q[wp_q] <= push_chan;
                wp_q        <= bump(wp_q);
            end
            if (do_pop) rp_q <= bump(rp_q);
            cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
            if (push && full)  ovf <= 1'b1;
            else if (ovf_clr)  ovf <= 1'b0;
        end
    end

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(DEPTH));

    // R9
    drop_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (push && full) |=> (ovf && cnt_q != '0));

    // R8
    push_seen_chk: assert property (@(posedge clk) disable iff (rst)
        (push && !full) |=> out_valid);
endmodule

// File: rtl/fbp_alloc.sv
module fbp_alloc
    import fbp_pkg::*;
#(
    parameter int IDX_W  = 3,
    parameter int CHAN_W = 8,
    parameter int QDEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic              rsp_ok,
    output logic [31:0]       rsp_ptr,
    input  logic              host_we,
    input  logic [IDX_W-1:0]  host_idx,
    input  logic [31:0]       host_ptr,
    input  logic              host_v,
    input  logic              host_w,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_base,
    input  logic [CHAN_W-1:0] cfg_chan,
    output logic [IDX_W-1:0]  fetch_idx,
    output logic              busy_evt,
    input  logic              host_busy_clr,
    output logic              irq_valid,
    input  logic              irq_ready,
    output logic [CHAN_W-1:0] irq_chan,
    output logic              irq_ovf,
    input  logic              host_ovf_clr
);
    fbp_ent_t          host_ent, rd_ent;
    logic              blk_clr, fail;
    logic [CHAN_W-1:0] chan_q;

    assign host_ent = '{v: host_v, w: host_w, ptr: host_ptr};

    fbp_table #(.IDX_W(IDX_W)) table_i (
        .clk(clk), .rst(rst),
        .host_we(host_we), .host_idx(host_idx), .host_ent(host_ent),
        .blk_clr(blk_clr), .blk_idx(fetch_idx),
        .rd_idx(fetch_idx), .rd_ent(rd_ent)
    );

    fbp_fetch #(.IDX_W(IDX_W)) fetch_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .rd_ent(rd_ent), .blk_clr(blk_clr),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_ptr(rsp_ptr),
        .cfg_we(cfg_we), .cfg_base(cfg_base),
        .idx(fetch_idx), .fail(fail)
    );

    fbp_irq_fifo #(.CHAN_W(CHAN_W), .DEPTH(QDEPTH)) irq_i (
        .clk(clk), .rst(rst),
        .push(fail), .push_chan(chan_q),
        .out_valid(irq_valid), .out_ready(irq_ready), .out_chan(irq_chan),
        .ovf(irq_ovf), .ovf_clr(host_ovf_clr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            chan_q   <= '0;
            busy_evt <= 1'b0;
        end else begin
            if (cfg_we) chan_q <= cfg_chan;
            if (fail)               busy_evt <= 1'b1;
            else if (host_busy_clr) busy_evt <= 1'b0;
        end
    end

    // R6
    busy_set_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ok) |=> busy_evt);

    // R7
    busy_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (host_busy_clr && !(rsp_valid && !rsp_ok)) |=> !busy_evt);
endmodule

// File: tb/fbp_alloc_tb.sv
module fbp_alloc_tb_top;
    localparam int IDX_W  = 3;
    localparam int CHAN_W = 8;
    localparam int QDEPTH = 4;
    localparam int NENT   = 1 << IDX_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 0, host_we = 0, host_v = 0, host_w = 0, cfg_we = 0;
    logic host_busy_clr = 0, irq_ready = 0, host_ovf_clr = 0;
    logic [IDX_W-1:0] host_idx = '0, cfg_base = '0;
    logic [31:0] host_ptr = '0;
    logic [CHAN_W-1:0] cfg_chan = '0;
    logic req_ready, rsp_valid, rsp_ok, busy_evt, irq_valid, irq_ovf;
    logic [31:0] rsp_ptr;
    logic [IDX_W-1:0] fetch_idx;
    logic [CHAN_W-1:0] irq_chan;

    int checks = 0, errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    fbp_alloc #(.IDX_W(IDX_W), .CHAN_W(CHAN_W), .QDEPTH(QDEPTH)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_ptr(rsp_ptr),
        .host_we(host_we), .host_idx(host_idx), .host_ptr(host_ptr),
        .host_v(host_v), .host_w(host_w), .cfg_we(cfg_we),
        .cfg_base(cfg_base), .cfg_chan(cfg_chan), .fetch_idx(fetch_idx),
        .busy_evt(busy_evt), .host_busy_clr(host_busy_clr),
        .irq_valid(irq_valid), .irq_ready(irq_ready), .irq_chan(irq_chan),
        .irq_ovf(irq_ovf), .host_ovf_clr(host_ovf_clr)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hwrite(input int idx, input logic [31:0] p, input bit v, input bit w);
        @(negedge clk);
        host_we = 1; host_idx = IDX_W'(idx); host_ptr = p; host_v = v; host_w = w;
        @(negedge clk);
        host_we = 0;
    endtask

    task automatic config_pool(input int base, input logic [CHAN_W-1:0] ch);
        @(negedge clk);
        cfg_we = 1; cfg_base = IDX_W'(base); cfg_chan = ch;
        @(negedge clk);
        cfg_we = 0;
        // R11
        chk(fetch_idx == IDX_W'(base), "R11", 64'(fetch_idx), 64'(base));
    endtask

    // Leaves the caller at the negedge inside the response cycle.
    task automatic fetch(output logic ok, output logic [31:0] p);
        @(negedge clk);
        req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        // R2
        chk(rsp_valid && !req_ready, "R2", {62'b0, rsp_valid, req_ready}, 64'h2);
        ok = rsp_ok;
        p  = rsp_ptr;
    endtask

    task automatic pop_irq(input logic [CHAN_W-1:0] exp);
        @(negedge clk);
        // R8
        chk(irq_valid && irq_chan == exp, "R8", 64'(irq_chan), 64'(exp));
        irq_ready = 1;
        @(negedge clk);
        irq_ready = 0;
    endtask

    task automatic clear_busy();
        @(negedge clk);
        host_busy_clr = 1;
        @(negedge clk);
        host_busy_clr = 0;
        // R7
        chk(!busy_evt, "R7", 64'(busy_evt), 0);
    endtask

    initial begin : main
        logic ok;
        logic [31:0] p;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1
        chk(req_ready && !rsp_valid && !busy_evt && !irq_valid && !irq_ovf && fetch_idx == 0,
            "R1", {58'b0, req_ready, rsp_valid, busy_evt, irq_valid, irq_ovf, 1'b0}, 64'h20);

        // R1: every entry starts with a cleared valid flag
        for (int i = 0; i < NENT; i++) begin
            config_pool(i, 8'h11);
            fetch(ok, p);
            chk(!ok && p == 0, "R1", {31'b0, ok, p}, 0);
            pop_irq(8'h11);
        end
        clear_busy();

        // Sweep: every base with every ring length that fits
        for (int b = 0; b < NENT; b++) begin
            for (int len = 1; len <= NENT - b; len++) begin
                logic [CHAN_W-1:0] ch;
                ch = CHAN_W'(b * 16 + len);
                for (int k = 0; k < len; k++)
                    hwrite(b + k, {8'hA0, 8'(b), 8'(len), 8'(k)}, 1'b1, k == len - 1);
                config_pool(b, ch);
                for (int k = 0; k < len; k++) begin
                    int exp_idx;
                    fetch(ok, p);
                    // R2
                    chk(ok && p == {8'hA0, 8'(b), 8'(len), 8'(k)}, "R2",
                        {31'b0, ok, p}, {32'h1, 8'hA0, 8'(b), 8'(len), 8'(k)});
                    @(negedge clk);
                    exp_idx = (k == len - 1) ? b : b + k + 1;
                    // R4 / R5
                    chk(fetch_idx == IDX_W'(exp_idx), (k == len - 1) ? "R5" : "R4",
                        64'(fetch_idx), 64'(exp_idx));
                end
                // R3: the first entry of the lap was consumed
                fetch(ok, p);
                chk(!ok && p == 0, "R3", {31'b0, ok, p}, 0);
                @(negedge clk);
                // R6
                chk(busy_evt && fetch_idx == IDX_W'(b), "R6",
                    {busy_evt, 60'b0, fetch_idx}, {1'b1, 60'b0, 3'(b)});
                pop_irq(ch);
                clear_busy();
            end
        end

        // R4: modulo step with no wrap flag anywhere
        for (int k = 0; k < NENT; k++) hwrite(k, 32'h5000 + k, 1'b1, 1'b0);
        config_pool(6, 8'h22);
        for (int k = 0; k < NENT; k++) begin
            fetch(ok, p);
            chk(ok && p == 32'h5000 + ((6 + k) % NENT), "R4", 64'(p),
                64'(32'h5000 + ((6 + k) % NENT)));
        end
        @(negedge clk);
        chk(fetch_idx == 6, "R4", 64'(fetch_idx), 6);

        // R10: host write lands on the entry being consumed in the same cycle
        hwrite(3, 32'hBEEF_0003, 1'b1, 1'b0);
        config_pool(3, 8'h33);
        fetch(ok, p);
        chk(ok && p == 32'hBEEF_0003, "R10", 64'(p), 64'hBEEF_0003);
        host_we = 1; host_idx = 3; host_ptr = 32'hCAFE_0003; host_v = 1; host_w = 0;
        @(negedge clk);
        host_we = 0;
        config_pool(3, 8'h33);
        fetch(ok, p);
        chk(ok && p == 32'hCAFE_0003, "R10", {31'b0, ok, p}, {32'h1, 32'hCAFE_0003});

        // R7: a failure in the clearing cycle keeps the event set
        config_pool(0, 8'h44);
        fetch(ok, p);
        chk(!ok, "R6", 64'(ok), 0);
        host_busy_clr = 1;
        @(negedge clk);
        host_busy_clr = 0;
        chk(busy_evt, "R7", 64'(busy_evt), 1);
        pop_irq(8'h44);
        clear_busy();

        // R8 / R9: order, then overflow with the queue never drained
        for (int n = 0; n < QDEPTH + 2; n++) begin
            config_pool(0, CHAN_W'(8'h60 + n));
            fetch(ok, p);
        end
        @(negedge clk);
        // R9
        chk(irq_ovf, "R9", 64'(irq_ovf), 1);
        for (int n = 0; n < QDEPTH; n++) pop_irq(CHAN_W'(8'h60 + n));
        @(negedge clk);
        chk(!irq_valid, "R9", 64'(irq_valid), 0);
        chk(irq_ovf, "R9", 64'(irq_ovf), 1);
        host_ovf_clr = 1;
        @(negedge clk);
        host_ovf_clr = 0;
        chk(!irq_ovf, "R9", 64'(irq_ovf), 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule